// File: doc/BRIEF.md
# SMBus Slave Command Engine

This block is the serial front end of a small register-mapped I/O expander. It runs entirely on a system clock. The SCL and SDA lines are oversampled through synchroniser chains, and START, STOP and clock edges are found by comparing successive samples. The engine pulls SDA low through an open-drain enable. It supports four transfers: write-byte, read-byte, send-byte and receive-byte. It acknowledges its own 7-bit address with either direction bit. It also acknowledges the alert response byte 0x19, and answers that byte with its own address.

Behind the protocol logic sits an 8-bit command pointer that persists across transactions. A small bank of six byte registers holds the output pattern and the rising/falling interrupt masks for two banks, normal and suspend. A write-byte lands in the register the pointer selects. Read-only, action and unknown codes redirect the write to register 00h. Two one-shot actions exist: reloading the slave address from the `own_addr` input, and a software reset that restores the bank's power-on values. Read data comes from the register bank, a snapshot of the `pins_i` inputs, or a fixed identity byte.

Top module: `smb_cmd_engine`

## Requirements
- R1: The engine drives an acknowledge only after an address byte whose upper seven bits equal the latched slave address (either R/W value), or after the exact byte 19h. For any other address byte it leaves SDA released until the next START.
- R2: Each byte is framed as eight data clocks, MSB first, sampled on SCL rising, plus a ninth acknowledge clock. The engine holds SDA low for the whole ninth clock of every byte it acknowledges, and never pulls SDA during the data bits of a byte it receives.
- R3: A write-byte with command 00h..05h stores the data byte into that register once the data acknowledge clock falls. The mapping is 00h `norm_out`, 01h `norm_rise_mask`, 02h `norm_fall_mask`, 03h `susp_out`, 04h `susp_rise_mask`, 05h `susp_fall_mask`.
- R4: A write-byte with any command code of 06h or above (read-only, action or unknown) stores its data into register 00h (`norm_out`). Any action tied to that code still runs.
- R5: A START or STOP that arrives before a byte has been completed discards that byte. No register changes, and the command pointer is unchanged if the interrupted byte was the command.
- R6: Read-byte and receive-byte return the byte selected by the last received command byte. Registers come from 00h..05h, and 06h returns `pins_i` as sampled when the acknowledge of the read address falls. FEh returns 4Dh, and every other code returns 00h. The pointer is kept between transactions.
- R7: Command 08h restores 00h and 03h to OUT_INIT (default FFh) and the four mask registers to MASK_INIT (FFh). It also reloads the slave address from `own_addr`. The pointer keeps the value 08h rather than returning to 00h.
- R8: The slave address is taken from `own_addr` in the first cycle after reset. After that it changes only when command 07h or 08h is received.
- R9: A read addressed with byte 19h returns the latched slave address shifted left by one, with bit 0 equal to 0.
- R10: During a read, a master acknowledge makes the engine send the selected byte again. A master not-acknowledge makes it release SDA for every following clock until the next START.
- R11: After reset SDA is released, all six registers hold their initial values and the command pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SMBus clock line level |
| sda_i | input | 1 | Raw SMBus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| own_addr | input | 7 | Slave address, latched at reset and on 07h/08h |
| pins_i | input | 8 | I/O pin levels returned by command 06h |
| norm_out | output | 8 | Register 00h, normal output pattern |
| norm_rise_mask | output | 8 | Register 01h, normal rising-edge mask |
| norm_fall_mask | output | 8 | Register 02h, normal falling-edge mask |
| susp_out | output | 8 | Register 03h, suspend output pattern |
| susp_rise_mask | output | 8 | Register 04h, suspend rising-edge mask |
| susp_fall_mask | output | 8 | Register 05h, suspend falling-edge mask |

## Verification
Each kind of fault in the engine's state shows at the pins within one byte time. A wrong bit counter moves or drops the acknowledge, and a wrong latched address acknowledges the wrong slave byte in the address sweep. A pointer that resets or drifts makes the next receive-byte return the wrong register. A wrong redirect or reset shows on the six register ports right after the STOP that ends the transaction. A stale transmit state keeps SDA low after a master NACK, and the clocks that follow catch it.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam int BYTE_W = 8;
    localparam int NUM_REGS = 6;
    localparam int REG_IW = $clog2(NUM_REGS);
    localparam logic [7:0] ALERT_RESP_BYTE = 8'h19;
    localparam logic [7:0] CMD_PIN_STATUS = 8'h06;
    localparam logic [7:0] CMD_RELOAD_ADDR = 8'h07;
    localparam logic [7:0] CMD_SOFT_RESET = 8'h08;
    localparam logic [7:0] CMD_IDENT = 8'hFE;
    localparam logic [7:0] IDENT_VALUE = 8'h4D;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_DATA,
        PH_TX,
        PH_DONE
    } phase_e;

    typedef struct packed {
        phase_e      phase;
        logic [3:0]  cnt;
        logic [7:0]  sh;
        logic        oe;
        logic [6:0]  addr;
        logic [7:0]  ptr;
        logic        ara;
        logic        mack;
        logic        loaded;
    } eng_state_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q, sync_d;
    logic              prev_q, prev_d;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign level = sync_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_pkg::*;
#(
    parameter logic [7:0] OUT_INIT  = 8'hFF,
    parameter logic [7:0] MASK_INIT = 8'hFF
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [REG_IW-1:0]               wr_idx,
    input  logic [BYTE_W-1:0]               wr_data,
    input  logic                            sw_rst,
    input  logic [7:0]                      rd_cmd,
    input  logic [BYTE_W-1:0]               pins,
    output logic [BYTE_W-1:0]               rd_data,
    output logic [NUM_REGS-1:0][BYTE_W-1:0] regs
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] INIT = (g % 3 == 0) ? OUT_INIT : MASK_INIT;
        logic [BYTE_W-1:0] r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (sw_rst) r_d = INIT;
            if (wr_en && wr_idx == REG_IW'(g)) r_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= INIT;
            else        r_q <= r_d;
        end

        assign regs[g] = r_q;
    end

    always_comb begin
        if (rd_cmd < 8'(NUM_REGS))       rd_data = regs[rd_cmd[REG_IW-1:0]];
        else if (rd_cmd == CMD_PIN_STATUS) rd_data = pins;
        else if (rd_cmd == CMD_IDENT)      rd_data = IDENT_VALUE;
        else                               rd_data = '0;
    end

    // R4
    redirect_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < REG_IW'(NUM_REGS)));

    // R7
    soft_reset_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rst && !wr_en) |=> (regs[0] == OUT_INIT && regs[3] == OUT_INIT &&
                                regs[1] == MASK_INIT && regs[2] == MASK_INIT &&
                                regs[4] == MASK_INIT && regs[5] == MASK_INIT));
endmodule

// File: rtl/smb_cmd_engine.sv
module smb_cmd_engine
    import smb_pkg::*;
#(
    parameter logic [7:0] OUT_INIT    = 8'hFF,
    parameter logic [7:0] MASK_INIT   = 8'hFF,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [6:0] own_addr,
    input  logic [7:0] pins_i,
    output logic [7:0] norm_out,
    output logic [7:0] norm_rise_mask,
    output logic [7:0] norm_fall_mask,
    output logic [7:0] susp_out,
    output logic [7:0] susp_rise_mask,
    output logic [7:0] susp_fall_mask
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] line_raw, line_lvl, line_rise, line_fall;
    assign line_raw = {sda_i, scl_i};

    for (genvar l = 0; l < NLINES; l++) begin : g_sync
        smb_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (line_raw[l]),
            .level(line_lvl[l]),
            .rise (line_rise[l]),
            .fall (line_fall[l])
        );
    end

    logic scl_hi, scl_rise, scl_fall, sda_lvl, bus_start, bus_stop;
    assign scl_hi    = line_lvl[0];
    assign scl_rise  = line_rise[0];
    assign scl_fall  = line_fall[0];
    assign sda_lvl   = line_lvl[1];
    assign bus_start = scl_hi & line_fall[1];
    assign bus_stop  = scl_hi & line_rise[1];

    eng_state_t s_q, s_d;

    logic                            wr_en, sw_rst;
    logic [REG_IW-1:0]               wr_idx;
    logic [7:0]                      wr_data, rd_data, load_byte;
    logic                            own_hit, ara_hit;
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;

    smb_regbank #(.OUT_INIT(OUT_INIT), .MASK_INIT(MASK_INIT)) i_regbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .sw_rst (sw_rst),
        .rd_cmd (s_q.ptr),
        .pins   (pins_i),
        .rd_data(rd_data),
        .regs   (regs)
    );

    always_comb begin
        s_d       = s_q;
        wr_en     = 1'b0;
        wr_idx    = '0;
        wr_data   = s_q.sh;
        sw_rst    = 1'b0;
        load_byte = s_q.ara ? {s_q.addr, 1'b0} : rd_data;
        own_hit   = (s_q.sh[7:1] == s_q.addr);
        ara_hit   = (s_q.sh == ALERT_RESP_BYTE);

        if (!s_q.loaded) begin
            s_d.addr   = own_addr;
            s_d.loaded = 1'b1;
        end

        if (bus_start) begin
            s_d.phase = PH_ADDR;
            s_d.cnt   = '0;
            s_d.oe    = 1'b0;
            s_d.ara   = 1'b0;
        end else if (bus_stop) begin
            s_d.phase = PH_IDLE;
            s_d.cnt   = '0;
            s_d.oe    = 1'b0;
        end else if (s_q.phase != PH_IDLE) begin
            if (scl_rise) begin
                if (s_q.cnt < 4'd8) begin
                    if (s_q.phase != PH_TX) s_d.sh = {s_q.sh[6:0], sda_lvl};
                    s_d.cnt = s_q.cnt + 4'd1;
                end else if (s_q.cnt == 4'd8) begin
                    s_d.cnt  = 4'd9;
                    s_d.mack = ~sda_lvl;
                end
            end else if (scl_fall) begin
                if (s_q.phase == PH_TX && s_q.cnt >= 4'd1 && s_q.cnt <= 4'd7) begin
                    s_d.sh = {s_q.sh[6:0], 1'b0};
                    s_d.oe = ~s_q.sh[6];
                end else if (s_q.cnt == 4'd8) begin
                    unique case (s_q.phase)
                        PH_ADDR: begin
                            if (own_hit || ara_hit) begin
                                s_d.oe  = 1'b1;
                                s_d.ara = ara_hit & ~own_hit;
                            end else begin
                                s_d.phase = PH_IDLE;
                            end
                        end
                        PH_CMD, PH_DATA: s_d.oe = 1'b1;
                        default:         s_d.oe = 1'b0;
                    endcase
                end else if (s_q.cnt == 4'd9) begin
                    s_d.cnt = '0;
                    s_d.oe  = 1'b0;
                    unique case (s_q.phase)
                        PH_ADDR: begin
                            if (s_q.sh[0]) begin
                                s_d.phase = PH_TX;
                                s_d.sh    = load_byte;
                                s_d.oe    = ~load_byte[7];
                            end else begin
                                s_d.phase = PH_CMD;
                            end
                        end
                        PH_CMD: begin
                            s_d.ptr   = s_q.sh;
                            s_d.phase = PH_DATA;
                            if (s_q.sh == CMD_RELOAD_ADDR || s_q.sh == CMD_SOFT_RESET)
                                s_d.addr = own_addr;
                            sw_rst = (s_q.sh == CMD_SOFT_RESET);
                        end
                        PH_DATA: begin
                            wr_en     = 1'b1;
                            wr_idx    = (s_q.ptr < 8'(NUM_REGS)) ? s_q.ptr[REG_IW-1:0] : '0;
                            s_d.phase = PH_DONE;
                        end
                        PH_TX: begin
                            if (s_q.mack) begin
                                s_d.sh = load_byte;
                                s_d.oe = ~load_byte[7];
                            end else begin
                                s_d.phase = PH_IDLE;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, sh: '0, oe: 1'b0, addr: '0,
                     ptr: '0, ara: 1'b0, mack: 1'b0, loaded: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_oe         = s_q.oe;
    assign norm_out       = regs[0];
    assign norm_rise_mask = regs[1];
    assign norm_fall_mask = regs[2];
    assign susp_out       = regs[3];
    assign susp_rise_mask = regs[4];
    assign susp_fall_mask = regs[5];

    // R10
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_IDLE) |-> !s_q.oe);

    // R5
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (!s_q.oe && s_q.cnt == 4'd0 && s_q.phase == PH_ADDR));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_fall |=> $stable(s_q.ptr));

    // R2
    ack_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.oe && (s_q.phase == PH_ADDR || s_q.phase == PH_CMD || s_q.phase == PH_DATA))
            |-> (s_q.cnt >= 4'd8));
endmodule

// File: tb/test_smb_cmd_engine.sv
module test_smb_cmd_engine;
    localparam int Q = 6;
    localparam logic [6:0] ADDR_A = 7'h25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [6:0] own_addr = ADDR_A;
    logic [7:0] pins_i = 8'h00;
    logic [7:0] norm_out, norm_rise_mask, norm_fall_mask;
    logic [7:0] susp_out, susp_rise_mask, susp_fall_mask;
    wire sda_line = sda_m & ~sda_oe;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [7:0] exp_reg [0:5];
    logic [7:0] exp_ptr;
    logic [6:0] cur_addr;

    always #4 clk = ~clk;

    smb_cmd_engine i_smb_cmd_engine (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .own_addr(own_addr), .pins_i(pins_i),
        .norm_out(norm_out), .norm_rise_mask(norm_rise_mask), .norm_fall_mask(norm_fall_mask),
        .susp_out(susp_out), .susp_rise_mask(susp_rise_mask), .susp_fall_mask(susp_fall_mask)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic put_bit(input logic b, output logic seen);
        sda_m = b; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        seen = sda_line;
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack, output bit clean);
        logic seen;
        clean = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            put_bit(v[i], seen);
            if (seen !== v[i]) clean = 1'b0;
        end
        put_bit(1'b1, seen);
        ack = (seen == 1'b0);
    endtask

    task automatic recv_byte(input bit master_ack, output logic [7:0] v);
        logic seen;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, seen);
            v[i] = seen;
        end
        put_bit(master_ack ? 1'b0 : 1'b1, seen);
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] code);
        if (code < 8'd6)      return exp_reg[code[2:0]];
        if (code == 8'h06)    return pins_i;
        if (code == 8'hFE)    return 8'h4D;
        return 8'h00;
    endfunction

    task automatic model_cmd(input logic [7:0] code);
        exp_ptr = code;
        if (code == 8'h07 || code == 8'h08) cur_addr = own_addr;
        if (code == 8'h08) begin
            exp_reg[0] = 8'hFF; exp_reg[3] = 8'hFF;
            exp_reg[1] = 8'hFF; exp_reg[2] = 8'hFF;
            exp_reg[4] = 8'hFF; exp_reg[5] = 8'hFF;
        end
    endtask

    task automatic check_regs(input string req);
        check(norm_out == exp_reg[0], req, "reg 00h", norm_out, exp_reg[0]);
        check(norm_rise_mask == exp_reg[1], req, "reg 01h", norm_rise_mask, exp_reg[1]);
        check(norm_fall_mask == exp_reg[2], req, "reg 02h", norm_fall_mask, exp_reg[2]);
        check(susp_out == exp_reg[3], req, "reg 03h", susp_out, exp_reg[3]);
        check(susp_rise_mask == exp_reg[4], req, "reg 04h", susp_rise_mask, exp_reg[4]);
        check(susp_fall_mask == exp_reg[5], req, "reg 05h", susp_fall_mask, exp_reg[5]);
    endtask

    task automatic write_byte(input logic [7:0] code, input logic [7:0] data);
        bit a0, a1, a2, c0, c1, c2;
        bus_start();
        send_byte({cur_addr, 1'b0}, a0, c0);
        send_byte(code, a1, c1);
        send_byte(data, a2, c2);
        bus_stop();
        check(a0 && a1 && a2, "R2", "write acks", {a0, a1, a2}, 3'b111);
        check(c0 && c1 && c2, "R2", "data bits undisturbed", {c0, c1, c2}, 3'b111);
        model_cmd(code);
        exp_reg[(code < 8'd6) ? code[2:0] : 3'd0] = data;
    endtask

    task automatic read_byte(input logic [7:0] code, output logic [7:0] v);
        bit a, c;
        bus_start();
        send_byte({cur_addr, 1'b0}, a, c);
        send_byte(code, a, c);
        model_cmd(code);
        bus_start();
        send_byte({cur_addr, 1'b1}, a, c);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    task automatic receive_byte(output logic [7:0] v);
        bit a, c;
        bus_start();
        send_byte({cur_addr, 1'b1}, a, c);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    task automatic send_cmd(input logic [7:0] code);
        bit a, c;
        bus_start();
        send_byte({cur_addr, 1'b0}, a, c);
        send_byte(code, a, c);
        bus_stop();
        model_cmd(code);
    endtask

    task automatic probe_addr(input logic [7:0] b, output bit ack);
        bit c;
        bus_start();
        send_byte(b, ack, c);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit ack, c;
        logic seen;
        logic [7:0] wl [0:13];
        wl = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
               8'h08, 8'h09, 8'h0A, 8'hFE, 8'hFF, 8'h80};
        for (int i = 0; i < 6; i++) exp_reg[i] = 8'hFF;
        exp_ptr = 8'h00;
        cur_addr = ADDR_A;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R11 reset state
        check(sda_oe == 1'b0, "R11", "sda released after reset", sda_oe, 0);
        check_regs("R11");
        pins_i = 8'hC3;
        receive_byte(v);
        check(v == exp_read(8'h00), "R11", "pointer 00h after reset", v, exp_read(8'h00));

        // R1 address sweep over all 7-bit addresses, write direction
        for (int a = 0; a < 128; a++) begin
            probe_addr({7'(a), 1'b0}, ack);
            check(ack == (7'(a) == ADDR_A), "R1", $sformatf("ack for address %0h", a),
                  ack, (7'(a) == ADDR_A));
        end
        probe_addr(8'h18, ack);
        check(!ack, "R1", "alert address with write bit", ack, 0);

        // R9 alert response returns latched address
        bus_start();
        send_byte(8'h19, ack, c);
        check(ack, "R1", "alert response byte acknowledged", ack, 1);
        recv_byte(1'b0, v);
        bus_stop();
        check(v == {ADDR_A, 1'b0}, "R9", "alert response data", v, {ADDR_A, 1'b0});

        // R3 / R4 write sweep
        for (int k = 0; k < 14; k++) begin
            write_byte(wl[k], 8'(wl[k] * 8'd29 + 8'd3));
            check_regs((wl[k] < 8'd6) ? "R3" : "R4");
        end

        // R6 read sweep
        for (int code = 0; code < 18; code++) begin
            logic [7:0] cc;
            cc = (code < 16) ? 8'(code) : ((code == 16) ? 8'hFE : 8'hFF);
            pins_i = 8'(cc * 8'd13) ^ 8'h5A;
            read_byte(cc, v);
            check(v == exp_read(cc), "R6", $sformatf("read code %0h", cc), v, exp_read(cc));
            if (cc == 8'h08) check_regs("R7");
        end
        receive_byte(v);
        check(v == 8'h00, "R6", "receive-byte keeps pointer FFh", v, 8'h00);
        read_byte(8'hFE, v);
        receive_byte(v);
        check(v == 8'h4D, "R6", "receive-byte keeps pointer FEh", v, 8'h4D);

        // R6 pin status captured at the read address acknowledge
        pins_i = 8'hA5;
        bus_start();
        send_byte({cur_addr, 1'b0}, ack, c);
        send_byte(8'h06, ack, c);
        model_cmd(8'h06);
        bus_start();
        send_byte({cur_addr, 1'b1}, ack, c);
        pins_i = 8'h3C;
        recv_byte(1'b0, v);
        bus_stop();
        check(v == 8'hA5, "R6", "pin snapshot at address ack", v, 8'hA5);

        // R7 soft reset keeps pointer at 08h, not 00h
        write_byte(8'h02, 8'h3C);
        write_byte(8'h00, 8'h11);
        send_cmd(8'h08);
        check_regs("R7");
        receive_byte(v);
        check(v == 8'h00, "R7", "pointer not cleared by soft reset", v, 8'h00);

        // R5 aborted transactions
        write_byte(8'h03, 8'h96);
        bus_start();
        send_byte({cur_addr, 1'b0}, ack, c);
        send_byte(8'h03, ack, c);
        for (int i = 0; i < 4; i++) put_bit(1'b0, seen);
        bus_stop();
        check_regs("R5");
        bus_start();
        send_byte({cur_addr, 1'b0}, ack, c);
        send_byte(8'h03, ack, c);
        for (int i = 0; i < 5; i++) put_bit(1'b1, seen);
        bus_start();
        send_byte({cur_addr, 1'b0}, ack, c);
        bus_stop();
        check_regs("R5");
        bus_start();
        send_byte({cur_addr, 1'b0}, ack, c);
        for (int i = 0; i < 3; i++) put_bit(1'b0, seen);
        bus_stop();
        receive_byte(v);
        check(v == 8'h96, "R5", "pointer kept after aborted command", v, 8'h96);

        // R10 master ack repeats byte, master nack releases the line
        write_byte(8'h01, 8'h6B);
        bus_start();
        send_byte({cur_addr, 1'b0}, ack, c);
        send_byte(8'h01, ack, c);
        bus_start();
        send_byte({cur_addr, 1'b1}, ack, c);
        recv_byte(1'b1, v);
        check(v == 8'h6B, "R10", "first read byte", v, 8'h6B);
        recv_byte(1'b0, v);
        check(v == 8'h6B, "R10", "byte repeated after master ack", v, 8'h6B);
        begin
            bit low_seen;
            low_seen = 1'b0;
            for (int i = 0; i < 9; i++) begin
                put_bit(1'b1, seen);
                if (seen == 1'b0) low_seen = 1'b1;
            end
            check(!low_seen, "R10", "line released after master nack", low_seen, 0);
        end
        bus_stop();

        // R8 address reload only on command 07h
        own_addr = 7'h51;
        probe_addr({7'h51, 1'b0}, ack);
        check(!ack, "R8", "new address ignored before reload", ack, 0);
        probe_addr({ADDR_A, 1'b0}, ack);
        check(ack, "R8", "old address kept before reload", ack, 1);
        send_cmd(8'h07);
        probe_addr({7'h51, 1'b0}, ack);
        check(ack, "R8", "new address after reload", ack, 1);
        probe_addr({ADDR_A, 1'b0}, ack);
        check(!ack, "R8", "old address dropped after reload", ack, 0);
        own_addr = 7'h2A;
        send_cmd(8'h08);
        probe_addr({7'h2A, 1'b0}, ack);
        check(ack, "R7", "soft reset reloads address", ack, 1);
        check_regs("R7");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule